// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Responder

This block is the logic one device needs to take part in a daisy-chained interrupt acknowledge. The processor starts an acknowledge cycle by driving an active-low grant into the first device of the chain. Each device decides once, on the first clock edge that sees the grant active, whether it has a request pending. If it does, it claims the cycle: it presents its interrupt vector and asserts an active-low transfer acknowledge until the grant goes away. If it does not, it forwards the grant on an active-low pass output to the next device and stays silent.

The vector is built from two fields. The upper five bits hold a device identity that software writes during initialization, and the lower bits hold a cause code supplied by the local request logic. Two devices on one chain are told apart by giving them different identities, such as 0 and 1. The whole vector is captured when the device claims the cycle. A later identity write or cause change therefore does not disturb a response already in progress.

A timeout monitor is also part of the block and is meant to be enabled on the last device of the chain. It counts clocks while the grant is active and no acknowledge has come. When the count reaches a parameterized limit, it raises a single-cycle abort pulse, so an acknowledge cycle that nobody answers still ends with an indication instead of a hung bus.

Top module: `irq_chain_responder`

## Requirements
- R1: While reset is held and in the first cycle after it, ack_n and pass_out_n are 1, vec_oe is 0, vec_out is all zeros and abort_pulse is 0.
- R2: If req_pending is 1 on the first clock edge at which grant_in_n is 0 (with the block idle), then from the next cycle ack_n is 0, vec_oe is 1 and vec_out equals {identity, cause_code} as they stood at that edge. The identity occupies bits [VEC_W-1:VEC_W-5] and the cause code occupies the bits below it.
- R3: If req_pending is 0 on that edge, then from the next cycle pass_out_n is 0, while ack_n stays 1 and vec_oe stays 0.
- R4: ack_n and pass_out_n are never 0 in the same cycle.
- R5: A claim or pass lasts while grant_in_n stays 0. On the first clock edge that sees grant_in_n at 1, the block releases: from the next cycle ack_n and pass_out_n are 1, vec_oe is 0 and vec_out is zero.
- R6: During a claim or pass, changes to req_pending, cause_code or the identity do not alter the decision or the presented vector.
- R7: A write with id_wr=1 loads id_wdata into the identity, which is used from the next acknowledge. Devices with identity 5'b00000 and 5'b00001 return vectors that differ in bit VEC_W-5.
- R8: After TMO_LIMIT consecutive clock edges with grant_in_n 0 and ack_n 1, abort_pulse is 1 for exactly one cycle, in the cycle after the last of those edges, and it is not raised again within the same grant.
- R9: A claimed cycle never raises abort_pulse, however long the grant is held.
- R10: A grant released before the limit clears the count, so abort_pulse stays 0 and the next grant starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_wr | input | 1 | Identity write strobe |
| id_wdata | input | ID_W | Identity value to store |
| cause_code | input | VEC_W-ID_W | Low vector bits from the local request logic |
| req_pending | input | 1 | Local request pending flag |
| grant_in_n | input | 1 | Active-low grant from the previous device or the processor |
| pass_out_n | output | 1 | Active-low grant forwarded to the next device |
| ack_n | output | 1 | Active-low transfer acknowledge |
| vec_oe | output | 1 | Vector drive enable for the data bus |
| vec_out | output | VEC_W | Vector presented during a claim, zero otherwise |
| abort_pulse | output | 1 | Single-cycle abort after an unanswered grant |

## Verification
Two situations are hard to reach from the ports. The first is a request, identity write or cause change that lands inside a cycle already decided. The bench reaches it by toggling req_pending, cause_code and id_wr at chosen negative edges while the grant is held low, and its reference model holds the decision taken on the first edge. The second is the timeout boundary. The bench holds unanswered grants for one cycle less than the limit, exactly the limit, and well past it, and records the cycle in which each abort pulse appears, which shows both the placement of the single pulse and the clearing of the count between grants.

// File: rtl/irqc_pkg.sv
// Package: shared types for the interrupt acknowledge responder.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package irqc_pkg;

    // Responder state: idle, claiming the cycle, or passing the grant on.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLAIM = 2'd1,
        ST_PASS  = 2'd2
    } resp_state_t;

endpackage

// File: rtl/irqc_vector_store.sv
// Module: holds the software-written identity and captures the full
// vector {identity, cause} when the responder claims a cycle.
// Assumes: cap_en is a single-cycle strobe raised on the claim decision.
module irqc_vector_store #(
    parameter int ID_W   = 5,
    parameter int CODE_W = 3,
    localparam int VEC_W = ID_W + CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_wr,
    input  logic [ID_W-1:0]   id_wdata,
    input  logic              cap_en,
    input  logic [CODE_W-1:0] code_in,
    output logic [VEC_W-1:0]  vec_q
);

    logic [ID_W-1:0] id_q;

    // Identity register, loaded by software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (id_wr) begin
            id_q <= id_wdata;
        end
    end

    // Vector capture at the claim decision, using the identity held before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (cap_en) begin
            vec_q <= {id_q, code_in};
        end
    end

endmodule

// File: rtl/irqc_grant_fsm.sv
// Module: decides once per grant whether to claim or pass, and holds that
// decision until the grant is seen released.
// Assumes: grant_n is synchronous to clk; pending is sampled only on the
// first edge that sees the grant active while idle.
module irqc_grant_fsm
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grant_n,
    input  logic pending,
    output logic cap_en,
    output logic ack_n,
    output logic pass_n,
    output logic drive
);

    resp_state_t state_q, state_d;

    // Next-state choice: decide on grant arrival, return to idle on grant release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!grant_n) begin
                    state_d = pending ? ST_CLAIM : ST_PASS;
                end
            end
            ST_CLAIM, ST_PASS: begin
                if (grant_n) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Capture strobe for the vector, raised on the claim decision edge.
    always_comb begin
        cap_en = (state_q == ST_IDLE) && !grant_n && pending;
    end

    // Output decode from the registered state.
    always_comb begin
        ack_n  = (state_q != ST_CLAIM);
        pass_n = (state_q != ST_PASS);
        drive  = (state_q == ST_CLAIM);
    end

endmodule

// File: rtl/irqc_timeout_mon.sv
// Module: counts clocks while the grant is active and no acknowledge has
// come, and pulses abort once when the count reaches LIMIT.
// Assumes: LIMIT >= 2; the count clears whenever the grant is released or
// an acknowledge is seen.
module irqc_timeout_mon #(
    parameter int LIMIT = 16,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_n,
    input  logic ack_n,
    output logic abort
);

    localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Wait counter that saturates at the limit, plus the single-cycle abort pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            abort <= 1'b0;
        end else begin
            abort <= 1'b0;
            if (grant_n || !ack_n) begin
                cnt_q <= '0;
            end else if (cnt_q != LIM_C) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST_C) begin
                    abort <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/irq_chain_responder.sv
// Module: top of one device's interrupt acknowledge responder. Claims the
// cycle with its vector when a request is pending, otherwise forwards the
// grant, and optionally watches for an unanswered grant.
// Assumes: all inputs synchronous to clk; TMO_EN is set on the last device.
module irq_chain_responder #(
    parameter int ID_W      = 5,
    parameter int VEC_W     = 8,
    parameter int TMO_LIMIT = 16,
    parameter bit TMO_EN    = 1'b1,
    localparam int CODE_W   = VEC_W - ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_wr,
    input  logic [ID_W-1:0]   id_wdata,
    input  logic [CODE_W-1:0] cause_code,
    input  logic              req_pending,
    input  logic              grant_in_n,
    output logic              pass_out_n,
    output logic              ack_n,
    output logic              vec_oe,
    output logic [VEC_W-1:0]  vec_out,
    output logic              abort_pulse
);

    logic             cap_en;
    logic [VEC_W-1:0] vec_q;

    irqc_vector_store #(
        .ID_W   (ID_W),
        .CODE_W (CODE_W)
    ) u_vec (
        .clk      (clk),
        .rst_n    (rst_n),
        .id_wr    (id_wr),
        .id_wdata (id_wdata),
        .cap_en   (cap_en),
        .code_in  (cause_code),
        .vec_q    (vec_q)
    );

    irqc_grant_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .grant_n (grant_in_n),
        .pending (req_pending),
        .cap_en  (cap_en),
        .ack_n   (ack_n),
        .pass_n  (pass_out_n),
        .drive   (vec_oe)
    );

    // Vector gating: the bus sees zeros unless the device is claiming.
    always_comb begin
        vec_out = vec_oe ? vec_q : '0;
    end

    generate
        if (TMO_EN) begin : g_tmo
            irqc_timeout_mon #(
                .LIMIT (TMO_LIMIT)
            ) u_tmo (
                .clk     (clk),
                .rst_n   (rst_n),
                .grant_n (grant_in_n),
                .ack_n   (ack_n),
                .abort   (abort_pulse)
            );
        end else begin : g_no_tmo
            assign abort_pulse = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/irqc_checker.sv
// Module: protocol assertions for the responder, bound to its top.
// Assumes: rst_n is synchronous and active low.
module irqc_checker #(
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grant_in_n,
    input logic             ack_n,
    input logic             pass_out_n,
    input logic [VEC_W-1:0] vec_out,
    input logic             abort_pulse
);

    // R4: never acknowledge and pass in the same cycle.
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ack_n && !pass_out_n));

    // R5: a claim persists while the grant is held.
    a_r5_claim_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !grant_in_n) |=> !ack_n);

    // R5: a claim ends on the clock after the grant is released.
    a_r5_claim_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && grant_in_n) |=> ack_n);

    // R3: a pass persists while the grant is held, with no acknowledge.
    a_r3_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_out_n && !grant_in_n) |=> (!pass_out_n && ack_n));

    // R6: the presented vector stays stable through a held claim.
    a_r6_vec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !grant_in_n) |=> $stable(vec_out));

    // R8: abort lasts a single cycle.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    // R9: no abort while the cycle is acknowledged.
    a_r9_no_abort_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n |-> !abort_pulse);

    // R10: a released grant clears any pending abort.
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        grant_in_n |=> !abort_pulse);

endmodule

bind irq_chain_responder irqc_checker #(.VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_in_n  (grant_in_n),
    .ack_n       (ack_n),
    .pass_out_n  (pass_out_n),
    .vec_out     (vec_out),
    .abort_pulse (abort_pulse)
);

// File: tb/tb_irq_chain_responder.sv
module tb_irq_chain_responder;

    localparam int ID_W   = 5;
    localparam int VEC_W  = 8;
    localparam int CODE_W = VEC_W - ID_W;
    localparam int LIMIT  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              id_wr = 1'b0;
    logic [ID_W-1:0]   id_wdata = '0;
    logic [CODE_W-1:0] cause_code = '0;
    logic              req_pending = 1'b0;
    logic              grant_in_n = 1'b1;
    logic              pass_out_n, ack_n, vec_oe, abort_pulse;
    logic [VEC_W-1:0]  vec_out;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    always #2 clk = ~clk;

    irq_chain_responder #(
        .ID_W(ID_W), .VEC_W(VEC_W), .TMO_LIMIT(LIMIT), .TMO_EN(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .id_wr(id_wr), .id_wdata(id_wdata),
        .cause_code(cause_code), .req_pending(req_pending),
        .grant_in_n(grant_in_n), .pass_out_n(pass_out_n), .ack_n(ack_n),
        .vec_oe(vec_oe), .vec_out(vec_out), .abort_pulse(abort_pulse)
    );

    // Reference model: 0 idle, 1 claim, 2 pass.
    int m_state = 0;
    int m_id = 0;
    int m_vec = 0;
    int m_cnt = 0;
    int m_abort = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_id = 0; m_vec = 0; m_cnt = 0; m_abort = 0;
        end else begin
            m_abort = 0;
            if (grant_in_n || m_state == 1) begin
                m_cnt = 0;
            end else if (m_cnt < LIMIT) begin
                if (m_cnt == LIMIT - 1) m_abort = 1;
                m_cnt = m_cnt + 1;
            end
            if (m_state == 0) begin
                if (!grant_in_n) begin
                    if (req_pending) begin
                        m_state = 1;
                        m_vec = m_id * (1 << CODE_W) + int'(cause_code);
                    end else begin
                        m_state = 2;
                    end
                end
            end else if (grant_in_n) begin
                m_state = 0;
            end
            if (id_wr) m_id = int'(id_wdata);
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_tag, "ack_n", int'(ack_n), (m_state == 1) ? 0 : 1);
            chk(cur_tag, "pass_out_n", int'(pass_out_n), (m_state == 2) ? 0 : 1);
            chk(cur_tag, "vec_oe", int'(vec_oe), (m_state == 1) ? 1 : 0);
            chk(cur_tag, "vec_out", int'(vec_out), (m_state == 1) ? m_vec : 0);
            chk(cur_tag, "abort_pulse", int'(abort_pulse), m_abort);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_id(input int v);
        id_wdata = ID_W'(v); id_wr = 1'b1;
        step(1);
        id_wr = 1'b0;
    endtask

    // Hold an unanswered grant for n cycles and return the abort count and first cycle.
    task automatic idle_grant(input int n, output int pulses, output int first);
        pulses = 0; first = -1;
        req_pending = 1'b0;
        grant_in_n = 1'b0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (abort_pulse) begin
                pulses++;
                if (first < 0) first = i;
            end
        end
        grant_in_n = 1'b1;
        step(2);
    endtask

    int pulses, first;

    initial begin
        // R1: reset state
        cur_tag = "R1";
        step(3);
        chk("R1", "ack_n in reset", int'(ack_n), 1);
        chk("R1", "pass_out_n in reset", int'(pass_out_n), 1);
        chk("R1", "vec_oe in reset", int'(vec_oe), 0);
        chk("R1", "abort in reset", int'(abort_pulse), 0);
        rst_n = 1'b1;
        step(1);
        chk("R1", "vec_out after reset", int'(vec_out), 0);

        // R7 and R2: identity 0, claim with cause 3
        cur_tag = "R2";
        write_id(0);
        cause_code = 3'd3; req_pending = 1'b1; grant_in_n = 1'b0;
        step(1);
        chk("R2", "ack_n claim", int'(ack_n), 0);
        chk("R7", "vector id0", int'(vec_out), 8'h03);
        step(3);
        cur_tag = "R5";
        grant_in_n = 1'b1;
        step(1);
        chk("R5", "ack_n release", int'(ack_n), 1);
        chk("R5", "vec_oe release", int'(vec_oe), 0);
        req_pending = 1'b0;
        step(2);

        // R7: identity 1 gives a different vector
        cur_tag = "R7";
        write_id(1);
        req_pending = 1'b1; grant_in_n = 1'b0;
        step(1);
        chk("R7", "vector id1", int'(vec_out), 8'h0B);
        grant_in_n = 1'b1;
        step(2);

        // R3: no request, grant forwarded
        cur_tag = "R3";
        req_pending = 1'b0; grant_in_n = 1'b0;
        step(1);
        chk("R3", "pass_out_n", int'(pass_out_n), 0);
        chk("R3", "ack_n silent", int'(ack_n), 1);
        // R6: request arriving mid-pass does not split the response
        cur_tag = "R6";
        req_pending = 1'b1;
        step(2);
        chk("R6", "still passing", int'(pass_out_n), 0);
        chk("R4", "no ack during pass", int'(ack_n), 1);
        grant_in_n = 1'b1;
        step(1);
        chk("R5", "pass released", int'(pass_out_n), 1);
        step(1);

        // R6: claim held through request drop, cause change and identity write
        cur_tag = "R6";
        cause_code = 3'd5; grant_in_n = 1'b0;
        step(1);
        req_pending = 1'b0; cause_code = 3'd2;
        write_id(7);
        step(2);
        chk("R6", "vector held", int'(vec_out), 8'h0D);
        chk("R4", "no pass during claim", int'(pass_out_n), 1);
        grant_in_n = 1'b1;
        step(2);
        // next claim picks up the new identity
        cur_tag = "R7";
        req_pending = 1'b1; grant_in_n = 1'b0;
        step(1);
        chk("R7", "new identity used", int'(vec_out), 8'h3A);
        grant_in_n = 1'b1;
        step(2);

        // R8: unanswered grant at and past the limit
        cur_tag = "R8";
        idle_grant(LIMIT + 8, pulses, first);
        chk("R8", "abort pulse count", pulses, 1);
        chk("R8", "abort cycle", first, LIMIT);
        idle_grant(LIMIT, pulses, first);
        chk("R8", "abort at exact limit", pulses, 1);

        // R10: released one short of the limit, twice in a row
        cur_tag = "R10";
        idle_grant(LIMIT - 1, pulses, first);
        chk("R10", "no abort short grant", pulses, 0);
        idle_grant(LIMIT - 1, pulses, first);
        chk("R10", "count cleared", pulses, 0);

        // R9: long claimed cycle
        cur_tag = "R9";
        pulses = 0;
        req_pending = 1'b1; grant_in_n = 1'b0;
        for (int i = 0; i < 3 * LIMIT; i++) begin
            @(negedge clk);
            if (abort_pulse) pulses++;
        end
        chk("R9", "no abort when claimed", pulses, 0);
        grant_in_n = 1'b1;
        step(1);

        // back-to-back grants, alternating decisions
        cur_tag = "R5";
        for (int k = 0; k < 6; k++) begin
            req_pending = k[0];
            cause_code = CODE_W'(k);
            grant_in_n = 1'b0;
            step(2 + k);
            grant_in_n = 1'b1;
            step(1);
        end
        step(3);

        // R1: reset in the middle of a claim
        cur_tag = "R1";
        req_pending = 1'b1; grant_in_n = 1'b0;
        step(2);
        rst_n = 1'b0;
        step(1);
        chk("R1", "ack_n after mid-claim reset", int'(ack_n), 1);
        grant_in_n = 1'b1;
        rst_n = 1'b1;
        step(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule